// File: doc/BRIEF.md
# Buffered Clock-Synchronous Serial Transmitter

This block is the transmit half of a clock-synchronous serial channel. Software places a byte in a one-entry holding buffer. The block moves the byte into a shift register at a shift-clock boundary and sends it out least significant bit first. The output line changes on each falling edge of the shift clock. The shift clock is either made internally by a divider or taken from an external pin through a synchronizer. The selected shift clock is also brought out, so a receiver can sample on its rising edge.

Two status flags report progress. One is set while the holding buffer is free. The other is set while the shifter is idle with nothing left to send. A sticky interrupt request fires when the selected flag goes from 0 to 1. The transmit enable bit is also the reset for the channel. Dropping it clears all transmit state. Raising it sets both flags at once, so an interrupt request follows the enable whichever source is selected. Because a buffer write is only taken at the next shift-clock boundary, the shift-complete flag drops 0.5 to 1.5 shift clocks after the write.

Top module: `sio_tx_top`

## Requirements
- R1: While txEnable is 0, bufEmpty, shiftDone and txIrq are 0 and serOut is 1. A wrStrobe given while disabled is discarded: after the next enable, no frame is sent and both flags stay 1.
- R2: One clock after txEnable goes from 0 to 1, bufEmpty and shiftDone are both 1.
- R3: One clock after txEnable goes from 0 to 1, txIrq is 1 for either value of irqSrcSel. txIrq then stays 1 until irqClear is pulsed.
- R4: One clock after an enabled wrStrobe, bufEmpty is 0. It returns to 1 in the clock in which the byte moves into the shift register.
- R5: A byte written while the shifter is idle enters the shifter at the first falling shift-clock edge that follows a rising edge seen after the write. shiftDone therefore falls 0.5 to 1.5 shift-clock periods after the write. External mode adds up to 4 clocks of synchronizer latency.
- R6: A frame is 8 bits sent least significant bit first. serOut changes only on falling shift-clock edges and is stable while sclkOut is high.
- R7: shiftDone returns to 1, with serOut at 1, on the falling edge that ends the eighth bit when no byte is waiting. If a byte is waiting, it follows without a gap and shiftDone stays 0.
- R8: irqSrcSel = 0 sets txIrq when bufEmpty goes from 0 to 1. irqSrcSel = 1 sets txIrq when shiftDone goes from 0 to 1. A rise of the other flag does not set it.
- R9: With clkSelExt = 1, extSclk passes through a two-stage synchronizer and becomes sclkOut. Frames are clocked by its edges, and an enable or a write made while extSclk is high is taken correctly.
- R10: With clkSelExt = 0, sclkOut toggles every DIV_HALF clocks, giving a period of 2*DIV_HALF clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txEnable | input | 1 | Transmit enable; 0 holds the channel in reset |
| clkSelExt | input | 1 | 1 selects extSclk as shift clock, 0 the internal divider |
| irqSrcSel | input | 1 | Interrupt source: 0 buffer empty, 1 shift complete |
| wrStrobe | input | 1 | One-clock write of wrData into the holding buffer |
| wrData | input | 8 | Byte to transmit |
| irqClear | input | 1 | One-clock clear of the sticky interrupt request |
| extSclk | input | 1 | External shift clock |
| bufEmpty | output | 1 | Holding buffer free |
| shiftDone | output | 1 | Shifter idle and no byte waiting |
| txIrq | output | 1 | Sticky transmit interrupt request |
| serOut | output | 1 | Serial data, idles high |
| sclkOut | output | 1 | Selected shift clock level |

## Verification
All flags and the interrupt request are registered. They are due one clock after an enable, write or clear, and the bench samples them on the falling clock edge that follows. The write-to-transfer delay is not fixed, because it depends on the shift-clock phase. The bench therefore counts clocks from the write until shiftDone falls, and checks the count against the 0.5 to 1.5 period window. It sweeps every write phase of the internal divider and every high-phase offset of the external clock. Serial bits are read half a shift period after each falling edge, on the rising edge of sclkOut, so a bit is never sampled while it is changing.

// File: rtl/sio_tx_pkg.sv
package sio_tx_pkg;
  typedef struct packed {
    logic clear;
    logic loadBuf;
    logic xfer;
    logic shiftBit;
    logic idle;
  } txStrobes_t;
endpackage

// File: rtl/sio_tx_datapath.sv
module sio_tx_datapath
  import sio_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              clkSelExt,
  input  logic              extSclk,
  input  logic [DATA_W-1:0] wrData,
  input  txStrobes_t        st,
  output logic              riseEv,
  output logic              fallEv,
  output logic              sclkOut,
  output logic              serOut
);
  localparam int DIV_W = $clog2(DIV_HALF) + 1;

  logic [DIV_W-1:0]       divCnt;
  logic                   sclkInt;
  logic                   divTerm;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   extLvl;
  logic                   extPrev;
  logic [DATA_W-1:0]      bufReg;
  logic [DATA_W-1:0]      shReg;

  assign divTerm = (divCnt == DIV_W'(DIV_HALF - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      sclkInt <= 1'b1;
    end else if (!txEnable || clkSelExt) begin
      divCnt  <= '0;
      sclkInt <= 1'b1;
    end else if (divTerm) begin
      divCnt  <= '0;
      sclkInt <= ~sclkInt;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : gSync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= extSclk;
      end
    end else begin : gSyncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], extSclk};
      end
    end
  endgenerate

  assign extLvl = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPrev <= 1'b1;
    else       extPrev <= extLvl;
  end

  always_comb begin
    if (clkSelExt) begin
      riseEv  = txEnable & extLvl & ~extPrev;
      fallEv  = txEnable & ~extLvl & extPrev;
      sclkOut = extLvl;
    end else begin
      riseEv  = txEnable & divTerm & ~sclkInt;
      fallEv  = txEnable & divTerm & sclkInt;
      sclkOut = sclkInt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufReg <= '0;
      shReg  <= '0;
      serOut <= 1'b1;
    end else begin
      if (st.loadBuf) bufReg <= wrData;
      if (st.clear) begin
        shReg  <= '0;
        serOut <= 1'b1;
      end else if (st.xfer) begin
        shReg  <= bufReg;
        serOut <= bufReg[0];
      end else if (st.shiftBit) begin
        shReg  <= shReg >> 1;
        serOut <= shReg[1];
      end else if (st.idle) begin
        serOut <= 1'b1;
      end
    end
  end

  AST_SEROUT_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && $past(txEnable) && !$stable(serOut)) |-> $past(fallEv)) // R6
    else $error("serOut changed away from a falling edge");
  AST_EDGES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(riseEv && fallEv)) // R10
    else $error("rise and fall events together");
endmodule

// File: rtl/sio_tx_ctrl.sv
module sio_tx_ctrl
  import sio_tx_pkg::*;
#(
  parameter int FRAME_BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic       irqSrcSel,
  input  logic       wrStrobe,
  input  logic       irqClear,
  input  logic       riseEv,
  input  logic       fallEv,
  output txStrobes_t st,
  output logic       bufEmpty,
  output logic       shiftDone,
  output logic       txIrq
);
  localparam int BIT_W = $clog2(FRAME_BITS);

  logic             enPrev, busy, armed;
  logic [BIT_W-1:0] bitCnt;
  logic             bufEmptyN, shiftDoneN, busyN, armedN, irqN, xfer;
  logic [BIT_W-1:0] bitCntN;

  always_comb begin
    bufEmptyN  = bufEmpty;
    shiftDoneN = shiftDone;
    busyN      = busy;
    armedN     = armed;
    bitCntN    = bitCnt;
    irqN       = txIrq;
    xfer       = 1'b0;
    st         = '0;
    if (!txEnable) begin
      st.clear   = 1'b1;
      bufEmptyN  = 1'b0;
      shiftDoneN = 1'b0;
      busyN      = 1'b0;
      armedN     = 1'b0;
      bitCntN    = '0;
      irqN       = 1'b0;
    end else begin
      if (!enPrev) begin
        bufEmptyN  = 1'b1;
        shiftDoneN = 1'b1;
      end else begin
        if (riseEv && !bufEmpty) armedN = 1'b1;
        if (fallEv) begin
          if (busy) begin
            if (bitCnt == BIT_W'(FRAME_BITS - 1)) begin
              if (armed) xfer = 1'b1;
              else begin
                busyN      = 1'b0;
                shiftDoneN = 1'b1;
                st.idle    = 1'b1;
              end
            end else begin
              st.shiftBit = 1'b1;
              bitCntN     = bitCnt + 1'b1;
            end
          end else if (armed) begin
            xfer = 1'b1;
          end
        end
        if (xfer) begin
          st.xfer    = 1'b1;
          armedN     = 1'b0;
          bufEmptyN  = 1'b1;
          busyN      = 1'b1;
          shiftDoneN = 1'b0;
          bitCntN    = '0;
        end
        if (wrStrobe) begin
          st.loadBuf = 1'b1;
          bufEmptyN  = 1'b0;
        end
      end
      if (irqClear) irqN = 1'b0;
      if (irqSrcSel ? (shiftDoneN && !shiftDone) : (bufEmptyN && !bufEmpty))
        irqN = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev    <= 1'b0;
      bufEmpty  <= 1'b0;
      shiftDone <= 1'b0;
      busy      <= 1'b0;
      armed     <= 1'b0;
      bitCnt    <= '0;
      txIrq     <= 1'b0;
    end else begin
      enPrev    <= txEnable;
      bufEmpty  <= bufEmptyN;
      shiftDone <= shiftDoneN;
      busy      <= busyN;
      armed     <= armedN;
      bitCnt    <= bitCntN;
      txIrq     <= irqN;
    end
  end

  AST_ENABLE_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEnable) |=> (bufEmpty && shiftDone)) // R2
    else $error("flags not set by enable");
  AST_ENABLE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEnable) |=> txIrq) // R3
    else $error("enable gave no interrupt request");
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && $past(txEnable) && $past(txIrq) && !$past(irqClear)) |-> txIrq) // R3
    else $error("interrupt request dropped without clear");
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> (!bufEmpty && !shiftDone && !txIrq)) // R1
    else $error("state left while disabled");
  AST_WRITE_FILLS_BUF: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && enPrev && wrStrobe) |=> !bufEmpty) // R4
    else $error("write did not clear buffer-empty");
  AST_DONE_FALLS_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && $past(txEnable) && $fell(shiftDone)) |-> $past(fallEv)) // R5
    else $error("shiftDone fell off a falling edge");
endmodule

// File: rtl/sio_tx_top.sv
module sio_tx_top
  import sio_tx_pkg::*;
#(
  parameter int DIV_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic       clkSelExt,
  input  logic       irqSrcSel,
  input  logic       wrStrobe,
  input  logic [7:0] wrData,
  input  logic       irqClear,
  input  logic       extSclk,
  output logic       bufEmpty,
  output logic       shiftDone,
  output logic       txIrq,
  output logic       serOut,
  output logic       sclkOut
);
  localparam int DATA_W = 8;

  txStrobes_t st;
  logic       riseEv, fallEv;

  sio_tx_ctrl #(.FRAME_BITS(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .irqSrcSel(irqSrcSel),
    .wrStrobe(wrStrobe), .irqClear(irqClear), .riseEv(riseEv), .fallEv(fallEv),
    .st(st), .bufEmpty(bufEmpty), .shiftDone(shiftDone), .txIrq(txIrq)
  );

  sio_tx_datapath #(.DATA_W(DATA_W), .DIV_HALF(DIV_HALF), .SYNC_STAGES(SYNC_STAGES)) uData (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .clkSelExt(clkSelExt),
    .extSclk(extSclk), .wrData(wrData), .st(st), .riseEv(riseEv),
    .fallEv(fallEv), .sclkOut(sclkOut), .serOut(serOut)
  );

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    shiftDone |-> serOut) // R7
    else $error("line not high while shifter idle");
endmodule

// File: tb/tb_sio_tx_top.sv
`timescale 1ns/1ps
module tb_sio_tx_top;
  localparam int DIV_HALF = 4;
  localparam int P        = 2 * DIV_HALF;
  localparam int EH       = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic txEnable = 0, clkSelExt = 0, irqSrcSel = 0, wrStrobe = 0, irqClear = 0;
  logic extSclk = 1'b1;
  logic [7:0] wrData = '0;
  logic bufEmpty, shiftDone, txIrq, serOut, sclkOut;
  int   checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  sio_tx_top #(.DIV_HALF(DIV_HALF)) dut (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .clkSelExt(clkSelExt),
    .irqSrcSel(irqSrcSel), .wrStrobe(wrStrobe), .wrData(wrData),
    .irqClear(irqClear), .extSclk(extSclk), .bufEmpty(bufEmpty),
    .shiftDone(shiftDone), .txIrq(txIrq), .serOut(serOut), .sclkOut(sclkOut)
  );

  always begin
    repeat (EH) @(negedge clk);
    extSclk = ~extSclk;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulseClear();
    @(negedge clk) irqClear = 1;
    @(negedge clk) irqClear = 0;
  endtask

  // expIrq: -1 skips, otherwise txIrq expected at the transfer
  task automatic sendFrame(input logic [7:0] d, input int lo, input int hi, input int expIrq);
    int n = 1;
    logic [7:0] got;
    @(negedge clk) begin wrData = d; wrStrobe = 1; end
    @(negedge clk) wrStrobe = 0;
    chk(bufEmpty == 0, "R4 write fills buffer", bufEmpty, 0);
    while (shiftDone && n < 1000) begin @(negedge clk); n++; end
    chk(n >= lo && n <= hi, "R5 write to shiftDone fall", n, lo);
    chk(bufEmpty == 1, "R4 buffer free after transfer", bufEmpty, 1);
    if (expIrq >= 0) chk(txIrq == expIrq[0], "R8 irq at transfer", txIrq, expIrq);
    for (int i = 0; i < 8; i++) begin
      @(posedge sclkOut); @(negedge clk); got[i] = serOut;
    end
    chk(got == d, "R6 frame bits", got, d);
    n = 0;
    while (!shiftDone && n < 1000) begin @(negedge clk); n++; end
    chk(shiftDone && serOut && n <= 3 * EH + 6, "R7 shiftDone after frame", n, 0);
  endtask

  initial begin
    logic [15:0] word;
    realtime t0;
    int ok;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(!bufEmpty && !shiftDone && !txIrq && serOut, "R1 reset state", {bufEmpty, shiftDone, txIrq, serOut}, 1);

    txEnable = 1;
    @(negedge clk);
    chk(bufEmpty && shiftDone, "R2 enable sets flags", {bufEmpty, shiftDone}, 3);
    chk(txIrq == 1, "R3 irq on enable src0", txIrq, 1);
    repeat (4) @(negedge clk);
    chk(txIrq == 1, "R3 irq sticky", txIrq, 1);
    pulseClear();
    chk(txIrq == 0, "R3 irq cleared", txIrq, 0);

    @(posedge sclkOut) t0 = $realtime;
    @(posedge sclkOut);
    chk(int'(($realtime - t0) / 5.0) == P, "R10 internal period", int'(($realtime - t0) / 5.0), P);

    for (int ph = 0; ph < 2 * P; ph++) begin
      repeat (ph) @(negedge clk);
      sendFrame(8'((ph * 37 + 5) & 8'hFF), P / 2, 3 * P / 2 + 1, -1);
    end

    // back-to-back frames
    @(negedge clk) begin wrData = 8'hA5; wrStrobe = 1; end
    @(negedge clk) wrStrobe = 0;
    while (shiftDone) @(negedge clk);
    @(negedge clk) begin wrData = 8'h3C; wrStrobe = 1; end
    @(negedge clk) wrStrobe = 0;
    ok = 1;
    for (int i = 0; i < 16; i++) begin
      @(posedge sclkOut); @(negedge clk);
      word[i] = serOut;
      if (shiftDone) ok = 0;
    end
    chk(ok == 1, "R7 no gap between frames", ok, 1);
    chk(word == 16'h3CA5, "R7 back-to-back data", word, 16'h3CA5);
    while (!shiftDone) @(negedge clk);

    // source select 0: buffer empty rise
    pulseClear();
    sendFrame(8'h81, P / 2, 3 * P / 2 + 1, 1);
    // source select 1: shift complete rise
    irqSrcSel = 1;
    pulseClear();
    chk(txIrq == 0, "R8 cleared before src1", txIrq, 0);
    sendFrame(8'h7E, P / 2, 3 * P / 2 + 1, 0);
    chk(txIrq == 1, "R8 irq on shift complete", txIrq, 1);

    // disable and writes while disabled
    @(negedge clk) txEnable = 0;
    @(negedge clk);
    chk(!bufEmpty && !shiftDone && !txIrq && serOut, "R1 disabled state", {bufEmpty, shiftDone, txIrq, serOut}, 1);
    @(negedge clk) begin wrData = 8'h55; wrStrobe = 1; end
    @(negedge clk) wrStrobe = 0;
    txEnable = 1;
    @(negedge clk);
    chk(txIrq == 1, "R3 irq on enable src1", txIrq, 1);
    ok = 1;
    repeat (3 * P) begin
      @(negedge clk);
      if (!shiftDone || !bufEmpty || !serOut) ok = 0;
    end
    chk(ok == 1, "R1 disabled write discarded", ok, 1);

    // external clock mode
    @(negedge clk) txEnable = 0;
    clkSelExt = 1;
    irqSrcSel = 0;
    @(posedge extSclk);
    repeat (3) @(negedge clk);
    txEnable = 1;
    @(negedge clk);
    chk(bufEmpty && shiftDone && txIrq, "R9 enable in external mode", {bufEmpty, shiftDone, txIrq}, 7);
    for (int k = 0; k < EH - 1; k++) begin
      @(posedge extSclk);
      repeat (k) @(negedge clk);
      sendFrame(8'((k * 53 + 9) & 8'hFF), EH, 3 * EH + 4, -1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule